// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block walks a ring of 8-byte transmit descriptors held in system memory. When kicked, it starts at its current descriptor pointer, reads each descriptor, copies the buffer that the descriptor points to into an internal staging buffer, and streams the completed frame out as bytes once a descriptor marked end-of-frame has been consumed. Each consumed descriptor is written back to memory with its ready bit cleared. The walk then moves on to the next descriptor, either 8 bytes further along or back to the ring base when the descriptor has its wrap bit set. The walk stops at the first descriptor that is not ready.

Memory is reached through a single 32-bit master port. A request holds its address, direction and write data steady until it is granted, and read data is taken in the granting cycle. Frame bytes leave on a valid/ready byte stream. Once valid is raised it stays high, with data and last held steady, until ready is seen. A low ready stalls the engine in its send phase and has no other effect. Three one-cycle event pulses tell the register unit that a buffer was consumed, that a frame ended, and that a frame overran the size cap.

Top module: `txr_ring_engine`

## Requirements
- R1: A kick pulse in idle starts a walk at the current descriptor pointer. A kick that arrives while a walk is in progress is remembered, and exactly one further walk starts after the engine has returned to idle.
- R2: A descriptor at address P consists of the word at P, which holds flags in bits 31:16 and byte length in bits 15:0, and the word at P+4, which holds the buffer byte address. Flag bit 15 is ready, bit 13 is wrap and bit 11 is end-of-frame. Memory is big-endian: the byte at address A sits in bits 31-8*(A mod 4) down to 24-8*(A mod 4) of the word at A with its two low bits cleared.
- R3: A walk ends at the first descriptor whose ready bit is 0. That descriptor is not written, and the pointer stays on it, so the next kick reads it again.
- R4: The buffer bytes of consecutive descriptors are appended in address order. After the end-of-frame descriptor has been copied, all accumulated bytes leave on the stream in order, with last set on the final byte only.
- R5: A frame holds at most MAX_FRAME bytes. Bytes of a buffer that would take the frame past that limit are dropped, and a babble event pulse is raised for that descriptor.
- R6: Each consumed descriptor's first word is written back to the descriptor's own address. The ready bit is cleared, and the other flags and the length are unchanged. This happens only after the descriptor's data has been fetched and, for an end-of-frame descriptor, after the frame has been sent.
- R7: After a descriptor is consumed, the pointer moves to the ring base if the wrap bit is set, and otherwise to the descriptor address plus 8.
- R8: Writing the ring base sets both the base and the current pointer to the written value with its two low bits cleared.
- R9: Every consumed descriptor raises a one-cycle buffer event. Every end-of-frame descriptor raises a one-cycle frame event.
- R10: While the stream's valid is high and ready is low, valid stays high and data and last are unchanged in the next cycle.
- R11: A memory request that is not granted is held in the next cycle with the same address, direction and write data.
- R12: Each kick starts with an empty frame, so bytes left over from a walk that stopped mid-frame are discarded. An end-of-frame descriptor that closes an empty frame raises the frame event but emits no bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kick_i | input | 1 | Start-walk pulse |
| base_we_i | input | 1 | Ring base write strobe |
| base_i | input | AW | Ring base value |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Word-aligned byte address |
| mem_wdata_o | output | 32 | Write data |
| mem_gnt_i | input | 1 | Request granted this cycle |
| mem_rdata_i | input | 32 | Read data, valid with grant |
| fo_valid_o | output | 1 | Frame byte valid |
| fo_ready_i | input | 1 | Sink accepts byte |
| fo_data_o | output | 8 | Frame byte |
| fo_last_o | output | 1 | Final byte of frame |
| ev_txb_o | output | 1 | Buffer consumed pulse |
| ev_txf_o | output | 1 | Frame ended pulse |
| ev_babt_o | output | 1 | Frame size cap hit pulse |

## Verification
The bench sweeps every buffer length from 1 to 12 at all four byte offsets. A wrong lane pick would scramble the bytes of unaligned buffers, and an off-by-one in the copy count would drop or repeat the final byte. It runs a ring that wraps with a zero-length middle fragment, and it re-kicks a stopped descriptor and a walk that stopped mid-frame. A design that ignored the wrap bit would read past the ring, and one that kept stale bytes between kicks would emit six bytes where two are expected. It also fills a frame exactly to the cap, overflows it, and kicks during a busy walk. A cap compare that is off by one would raise the babble event at exactly the limit, and a design that dropped the latched kick would show only one read of the stopping descriptor instead of two.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_BD,
    ST_COPY,
    ST_SEND,
    ST_WRITEBACK,
    ST_ADVANCE
  } txr_state_e;

  localparam int FLAG_READY = 15;
  localparam int FLAG_WRAP  = 13;
  localparam int FLAG_LAST  = 11;
  localparam int BD_STRIDE  = 8;

  // big-endian lane select: lane 0 is the most significant byte
  function automatic logic [7:0] lane_pick(input logic [31:0] w, input logic [1:0] lane);
    logic [7:0] b;
    case (lane)
      2'd0:    b = w[31:24];
      2'd1:    b = w[23:16];
      2'd2:    b = w[15:8];
      default: b = w[7:0];
    endcase
    return b;
  endfunction
endpackage

// File: rtl/txr_stage_buf.sv
module txr_stage_buf #(
  parameter int DEPTH = 2032,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_byte_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_byte_o
);
  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) store[wr_idx_i] <= wr_byte_i;
  end

  assign rd_byte_o = store[rd_idx_i];
endmodule

// File: rtl/txr_frame_sender.sv
module txr_frame_sender #(
  parameter int CNT_W = 11,
  parameter int IDX_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [IDX_W-1:0] rd_idx_o,
  input  logic [7:0]       rd_byte_i,
  output logic             fo_valid_o,
  input  logic             fo_ready_i,
  output logic [7:0]       fo_data_o,
  output logic             fo_last_o,
  output logic             done_o
);
  logic [CNT_W-1:0] idx_q;
  logic             at_end;

  assign at_end     = (idx_q == len_i - CNT_W'(1));
  assign rd_idx_o   = idx_q[IDX_W-1:0];
  assign fo_valid_o = go_i;
  assign fo_data_o  = rd_byte_i;
  assign fo_last_o  = go_i && at_end;
  assign done_o     = go_i && fo_ready_i && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  idx_q <= '0;
    else if (go_i && fo_ready_i) idx_q <= at_end ? '0 : idx_q + CNT_W'(1);
  end

  // R10: stalled byte is held
  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    fo_valid_o && !fo_ready_i |=> fo_valid_o && $stable(fo_data_o) && $stable(fo_last_o));
endmodule

// File: rtl/txr_ring_engine.sv
module txr_ring_engine #(
  parameter int AW        = 32,
  parameter int MAX_FRAME = 2032
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          kick_i,
  input  logic          base_we_i,
  input  logic [AW-1:0] base_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic          mem_gnt_i,
  input  logic [31:0]   mem_rdata_i,
  output logic          fo_valid_o,
  input  logic          fo_ready_i,
  output logic [7:0]    fo_data_o,
  output logic          fo_last_o,
  output logic          ev_txb_o,
  output logic          ev_txf_o,
  output logic          ev_babt_o
);
  import txr_pkg::*;

  localparam int CNT_W = $clog2(MAX_FRAME + 1);
  localparam int IDX_W = $clog2(MAX_FRAME);

  txr_state_e       state_q;
  logic             word_sel_q, kick_pend_q;
  logic [AW-1:0]    base_q, cur_q, bufa_q;
  logic [15:0]      flags_q, len_q;
  logic [CNT_W-1:0] cnt_q, off_q, acc_q;

  logic             gnt;
  logic [AW-1:0]    byte_addr;
  logic [16:0]      room_w, need_w;
  logic             over_w;
  logic [CNT_W-1:0] take_w;
  txr_state_e       after_copy;
  logic [15:0]      wb_flags;
  logic [IDX_W-1:0] rd_idx;
  logic [7:0]       rd_byte;
  logic             snd_go, snd_done;

  assign mem_req_o = (state_q == ST_FETCH_BD) || (state_q == ST_COPY) || (state_q == ST_WRITEBACK);
  assign mem_we_o  = (state_q == ST_WRITEBACK);
  assign gnt       = mem_req_o && mem_gnt_i;
  assign byte_addr = bufa_q + AW'(off_q);

  always_comb begin
    wb_flags             = flags_q;
    wb_flags[FLAG_READY] = 1'b0;
  end

  always_comb begin
    case (state_q)
      ST_FETCH_BD:  mem_addr_o = cur_q + (word_sel_q ? AW'(4) : AW'(0));
      ST_COPY:      mem_addr_o = byte_addr & ~AW'(3);
      ST_WRITEBACK: mem_addr_o = cur_q;
      default:      mem_addr_o = '0;
    endcase
  end
  assign mem_wdata_o = (state_q == ST_WRITEBACK) ? {wb_flags, len_q} : 32'd0;

  // clip this buffer against the room left in the frame
  assign room_w     = 17'(MAX_FRAME) - 17'(acc_q);
  assign need_w     = {1'b0, len_q};
  assign over_w     = need_w > room_w;
  assign take_w     = over_w ? room_w[CNT_W-1:0] : need_w[CNT_W-1:0];
  assign after_copy = flags_q[FLAG_LAST] ? ST_SEND : ST_WRITEBACK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      word_sel_q  <= 1'b0;
      kick_pend_q <= 1'b0;
      base_q      <= '0;
      cur_q       <= '0;
      bufa_q      <= '0;
      flags_q     <= '0;
      len_q       <= '0;
      cnt_q       <= '0;
      off_q       <= '0;
      acc_q       <= '0;
      ev_txb_o    <= 1'b0;
      ev_txf_o    <= 1'b0;
      ev_babt_o   <= 1'b0;
    end else begin
      ev_txb_o  <= 1'b0;
      ev_txf_o  <= 1'b0;
      ev_babt_o <= 1'b0;
      if (state_q != ST_IDLE && kick_i) kick_pend_q <= 1'b1;
      case (state_q)
        ST_IDLE: begin
          if (kick_i || kick_pend_q) begin
            state_q     <= ST_FETCH_BD;
            word_sel_q  <= 1'b0;
            acc_q       <= '0;
            kick_pend_q <= 1'b0;
          end
        end
        ST_FETCH_BD: begin
          if (gnt) begin
            if (!word_sel_q) begin
              flags_q <= mem_rdata_i[31:16];
              len_q   <= mem_rdata_i[15:0];
              if (!mem_rdata_i[16+FLAG_READY]) state_q <= ST_IDLE;
              else                             word_sel_q <= 1'b1;
            end else begin
              bufa_q     <= mem_rdata_i[AW-1:0];
              word_sel_q <= 1'b0;
              off_q      <= '0;
              cnt_q      <= take_w;
              ev_babt_o  <= over_w;
              state_q    <= (take_w == '0) ? after_copy : ST_COPY;
            end
          end
        end
        ST_COPY: begin
          if (gnt) begin
            acc_q <= acc_q + CNT_W'(1);
            off_q <= off_q + CNT_W'(1);
            if (off_q == cnt_q - CNT_W'(1)) state_q <= after_copy;
          end
        end
        ST_SEND: begin
          if (acc_q == '0 || snd_done) begin
            ev_txf_o <= 1'b1;
            acc_q    <= '0;
            state_q  <= ST_WRITEBACK;
          end
        end
        ST_WRITEBACK: begin
          if (gnt) begin
            ev_txb_o <= 1'b1;
            state_q  <= ST_ADVANCE;
          end
        end
        ST_ADVANCE: begin
          cur_q      <= flags_q[FLAG_WRAP] ? base_q : cur_q + AW'(BD_STRIDE);
          word_sel_q <= 1'b0;
          state_q    <= ST_FETCH_BD;
        end
        default: state_q <= ST_IDLE;
      endcase
      if (base_we_i) begin
        base_q <= base_i & ~AW'(3);
        cur_q  <= base_i & ~AW'(3);
      end
    end
  end

  txr_stage_buf #(.DEPTH(MAX_FRAME), .IDX_W(IDX_W)) u_stage (
    .clk       (clk),
    .wr_en_i   (gnt && (state_q == ST_COPY)),
    .wr_idx_i  (acc_q[IDX_W-1:0]),
    .wr_byte_i (lane_pick(mem_rdata_i, byte_addr[1:0])),
    .rd_idx_i  (rd_idx),
    .rd_byte_o (rd_byte)
  );

  assign snd_go = (state_q == ST_SEND) && (acc_q != '0);

  txr_frame_sender #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_send (
    .clk        (clk),
    .rst_n      (rst_n),
    .go_i       (snd_go),
    .len_i      (acc_q),
    .rd_idx_o   (rd_idx),
    .rd_byte_i  (rd_byte),
    .fo_valid_o (fo_valid_o),
    .fo_ready_i (fo_ready_i),
    .fo_data_o  (fo_data_o),
    .fo_last_o  (fo_last_o),
    .done_o     (snd_done)
  );

  // R11: ungranted request is held unchanged
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o));
  // R6: a write-back never leaves the ready bit set
  a_r6_wb_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_o && mem_we_o |-> !mem_wdata_o[31]);
  // R5: accumulated length never passes the cap
  a_r5_acc_bound: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q <= CNT_W'(MAX_FRAME));
  // R4: sending happens only for an end-of-frame descriptor
  a_r4_send_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND) |-> flags_q[FLAG_LAST]);
  // R9: buffer event follows a granted write-back
  a_r9_txb_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ev_txb_o) |-> $past(mem_req_o && mem_we_o && mem_gnt_i));
endmodule

// File: tb/txr_ring_engine_tb.sv
module txr_ring_engine_tb;
  localparam int AW  = 32;
  localparam int MAX = 48;
  localparam logic [15:0] F_RDY = 16'h8000, F_WRAP = 16'h2000, F_LAST = 16'h0800;

  logic clk = 1'b0, rst_n = 1'b0, kick_i = 1'b0, base_we_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic mem_req_o, mem_we_o, mem_gnt_i = 1'b0;
  logic [AW-1:0] mem_addr_o;
  logic [31:0] mem_wdata_o, mem_rdata_i = '0;
  logic fo_valid_o, fo_ready_i = 1'b0, fo_last_o;
  logic [7:0] fo_data_o;
  logic ev_txb_o, ev_txf_o, ev_babt_o;

  always #10 clk = ~clk;

  txr_ring_engine #(.AW(AW), .MAX_FRAME(MAX)) u_dut (.*);

  logic [31:0] mem [64];
  logic [7:0]  rx_buf [256];
  logic [7:0]  exp_buf [256];
  int rx_n, exp_n, frames, last_at, n_txb, n_txf, n_babt, n_wr, watch_rd, hold_bad;
  int vec = 0, miss = 0, cyc = 0, quiet = 0;
  logic [AW-1:0] watch_addr = '1;
  bit timeout = 0;
  logic prev_v = 0, prev_r = 0;
  logic [7:0] prev_d = 0;

  // memory slave, stream sink and event capture, all at the falling edge
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) timeout = 1;
    if (prev_v && !prev_r && (!fo_valid_o || fo_data_o != prev_d)) hold_bad++;
    fo_ready_i = (cyc % 4) != 3;
    mem_gnt_i  = mem_req_o && ((cyc % 3) != 2);
    mem_rdata_i = mem[mem_addr_o[7:2]];
    if (mem_req_o && mem_gnt_i) begin
      if (mem_we_o) begin mem[mem_addr_o[7:2]] = mem_wdata_o; n_wr++; end
      else if (mem_addr_o == watch_addr) watch_rd++;
    end
    if (fo_valid_o && fo_ready_i) begin
      rx_buf[rx_n[7:0]] = fo_data_o; rx_n++;
      if (fo_last_o) begin frames++; last_at = rx_n; end
    end
    if (ev_txb_o) n_txb++;
    if (ev_txf_o) n_txf++;
    if (ev_babt_o) n_babt++;
    prev_v = fo_valid_o; prev_r = fo_ready_i; prev_d = fo_data_o;
    quiet = (mem_req_o || fo_valid_o) ? 0 : quiet + 1;
  end

  function automatic logic [7:0] byte_at(input int a);
    logic [31:0] w = mem[a[7:2]];
    return w[31 - 8*a[1:0] -: 8];
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vec++;
    if (!ok) begin miss++; $display("FAIL %s actual=%0h expected=%0h", tag, act, exp); end
  endtask

  task automatic clear_caps();
    rx_n = 0; exp_n = 0; frames = 0; last_at = -1; n_txb = 0; n_txf = 0; n_babt = 0;
    n_wr = 0; watch_rd = 0;
  endtask

  task automatic add_exp(input int a, input int n);
    for (int i = 0; i < n; i++) begin exp_buf[exp_n[7:0]] = byte_at(a + i); exp_n++; end
  endtask

  task automatic set_bd(input int p, input logic [15:0] f, input int len, input int b);
    mem[p[7:2]] = {f, 16'(len)};
    mem[p[7:2] + 6'd1] = 32'(b);
  endtask

  task automatic set_base(input logic [AW-1:0] b);
    @(negedge clk); base_i = b; base_we_i = 1'b1;
    @(negedge clk); base_we_i = 1'b0;
  endtask

  task automatic kick();
    @(negedge clk); kick_i = 1'b1;
    @(negedge clk); kick_i = 1'b0;
  endtask

  task automatic wait_quiet();
    @(negedge clk);
    while (quiet < 40 && !timeout) @(negedge clk);
  endtask

  task automatic check_bytes(input string tag);
    int bad = 0;
    for (int i = 0; i < exp_n && i < rx_n; i++) if (rx_buf[i] != exp_buf[i]) bad++;
    chk(bad == 0 && rx_n == exp_n, tag, rx_n + (bad << 16), exp_n);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int a = 128; a < 256; a++) mem[a/4][31 - 8*(a%4) -: 8] = 8'(a*7 + 3);
    clear_caps(); hold_bad = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R9: idle after reset
    chk(!mem_req_o && !fo_valid_o && !ev_txb_o && !ev_txf_o && !ev_babt_o, "R1 reset idle",
        {mem_req_o, fo_valid_o, ev_txb_o, ev_txf_o, ev_babt_o}, 0);

    // R2 R4 R6 R9: every length 1..12 at every byte offset
    for (int len = 1; len <= 12 && !timeout; len++)
      for (int off = 0; off < 4; off++) begin
        set_base(0);
        set_bd(0, F_RDY | F_LAST, len, 128 + off);
        set_bd(8, 16'h0, 0, 0);
        clear_caps(); add_exp(128 + off, len);
        kick(); wait_quiet();
        check_bytes("R2 R4 sweep bytes");
        chk(frames == 1 && last_at == len, "R4 sweep last flag", last_at, len);
        chk(n_txb == 1 && n_txf == 1 && n_babt == 0, "R9 sweep events", {n_txb, n_txf, n_babt}, 32'h110);
        chk(mem[0] == {F_LAST, 16'(len)}, "R6 sweep writeback", mem[0], {F_LAST, 16'(len)});
      end

    // R4 R7: fragmented frame with zero-length middle, then wrapping frame
    set_base(0);
    set_bd(0, F_RDY, 3, 144);
    set_bd(8, F_RDY, 0, 0);
    set_bd(16, F_RDY | F_LAST, 7, 161);
    set_bd(24, F_RDY | F_LAST | F_WRAP, 2, 179);
    clear_caps(); add_exp(144, 3); add_exp(161, 7); add_exp(179, 2);
    kick(); wait_quiet();
    check_bytes("R4 multi fragment bytes");
    chk(frames == 2 && last_at == 12, "R4 multi frame ends", frames, 2);
    chk(n_txb == 4 && n_txf == 2, "R9 multi events", {n_txb, n_txf}, 32'h40002);
    chk(mem[0] == 32'h0000_0003 && mem[6] == {F_WRAP | F_LAST, 16'd2}, "R6 multi writeback", mem[6], {F_WRAP | F_LAST, 16'd2});
    // R7: pointer wrapped to base
    set_bd(0, F_RDY | F_LAST, 1, 192);
    clear_caps(); add_exp(192, 1);
    kick(); wait_quiet();
    check_bytes("R7 wrap to base");
    // R3: pointer now at 8 which is not ready; nothing written, nothing sent
    clear_caps(); watch_addr = 8;
    kick(); wait_quiet();
    chk(rx_n == 0 && n_wr == 0 && watch_rd == 1, "R3 stop on not ready", {rx_n, n_wr, watch_rd}, 1);
    set_bd(8, F_RDY | F_LAST, 2, 200);
    clear_caps(); add_exp(200, 2);
    kick(); wait_quiet();
    check_bytes("R3 resume at stopped descriptor");

    // R8 R12: unaligned base write, then a walk that stops mid-frame
    set_bd(64, F_RDY, 4, 144);
    set_bd(72, 16'h0, 0, 0);
    clear_caps(); watch_addr = 64;
    set_base(67);
    kick(); wait_quiet();
    chk(watch_rd == 1 && rx_n == 0 && n_txb == 1, "R8 base aligned down", watch_rd, 1);
    set_bd(72, F_RDY | F_LAST, 2, 208);
    clear_caps(); add_exp(208, 2);
    kick(); wait_quiet();
    check_bytes("R12 stale bytes dropped");

    // R5: exactly at the cap, no babble
    set_base(0);
    set_bd(0, F_RDY | F_LAST, MAX, 128);
    set_bd(8, 16'h0, 0, 0);
    clear_caps(); add_exp(128, MAX);
    kick(); wait_quiet();
    check_bytes("R5 exact cap bytes");
    chk(n_babt == 0, "R5 no babble at cap", n_babt, 0);

    // R5 R6: overflow truncates and flags babble
    set_base(0);
    set_bd(0, F_RDY, 30, 128);
    set_bd(8, F_RDY | F_LAST, 30, 128);
    set_bd(16, 16'h0, 0, 0);
    clear_caps(); add_exp(128, 30); add_exp(128, MAX - 30);
    kick(); wait_quiet();
    check_bytes("R5 truncated bytes");
    chk(n_babt == 1 && frames == 1 && last_at == MAX, "R5 babble event", {n_babt, last_at}, {32'(1), 32'(MAX)});
    chk(mem[2] == {F_LAST, 16'd30}, "R6 length kept on truncation", mem[2], {F_LAST, 16'd30});

    // R12: zero-length frame
    set_base(0);
    set_bd(0, F_RDY | F_LAST, 0, 0);
    set_bd(8, 16'h0, 0, 0);
    clear_caps();
    kick(); wait_quiet();
    chk(rx_n == 0 && n_txf == 1 && n_txb == 1, "R12 empty frame", {rx_n, n_txf}, 1);

    // R1: kick while busy reruns once
    set_base(0);
    set_bd(0, F_RDY | F_LAST, 20, 128);
    set_bd(8, 16'h0, 0, 0);
    clear_caps(); watch_addr = 8;
    kick(); repeat (3) @(negedge clk); kick(); wait_quiet();
    chk(watch_rd == 2 && frames == 1, "R1 latched kick", watch_rd, 2);

    // R10: held byte under back-pressure
    chk(hold_bad == 0, "R10 stream hold", hold_bad, 0);
    chk(!timeout, "watchdog", timeout, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end

  initial begin
    wait (timeout);
    miss++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", vec, miss);
    $finish;
  end
endmodule